// File: doc/BRIEF.md
# CAN Controller Interrupt Collector

This block merges the five interrupt causes of a small CAN message controller into a single request line for the CPU. Each cause is caught in a sticky flag: a finished reception, a finished transmission, any change of the error or bus status bits, a message lost because both receive buffers are still held, and bus activity seen while the controller sleeps.

Software programs one enable bit per cause in a control register. The wake cause has no enable bit and always raises the request. Software reads the pending causes from a source register and acknowledges them by writing ones to the same offset. The block also presents the fixed address of the handler vector, whose high byte sits at that address and whose low byte sits at the next one.

Top module: `can_irq_collector`

## Requirements
- R1: After reset all flags and all enable bits are 0, `irq_req` is 0, and reads at offsets 0 and 3 return 0.
- R2: A high `rx_done` in a cycle sets source bit 0, and a high `tx_done` sets source bit 1. Each bit reads as 1 at offset 3 from the next clock edge on.
- R3: Source bit 2 sets on the clock edge after `err_stat` or `bus_stat` (each 2 bits) takes a value that differs from the previous cycle, whether bits rise or fall. Steady values never set it, and neither does the first sample taken after reset.
- R4: Source bit 3 (overrun) sets when `msg_arrive` is high while both bits of `buf_full` are 1. An arrival with at most one buffer full does not set it.
- R5: Source bit 4 (wake) sets when `bus_active` is high while `sleep_mode` is high. Bus activity outside sleep does not set it.
- R6: `irq_req` is the OR of source bits 0 to 3, each ANDed with control bit 0 to 3 at offset 0, ORed with source bit 4 unmasked. Control bit 4 reads as 0.
- R7: A write to offset 3 clears every flag whose data bit is 1 and leaves the others unchanged. When an event arrives in the same cycle as its clear, the flag stays set.
- R8: `vec_addr` is 0x1FFA, the address of the handler's high byte. The low byte sits at 0x1FFB.
- R9: Offsets 1 and 2 read as 0, and writes to them change neither the enables nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | Reception complete strobe |
| tx_done | input | 1 | Transmission complete strobe |
| err_stat | input | 2 | Error status bits |
| bus_stat | input | 2 | Bus status bits |
| buf_full | input | 2 | Occupancy of the two receive buffers |
| msg_arrive | input | 1 | Incoming message strobe |
| bus_active | input | 1 | Activity seen on the bus |
| sleep_mode | input | 1 | Controller is asleep |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_req | output | 1 | Combined interrupt request |
| vec_addr | output | 16 | Handler vector address (high byte) |

## Verification
A wrong flag shows at offset 3 and, when its enable is set, on `irq_req` at the first clock edge after the event or clear. A stale copy of the status bits shows as a spurious or missing bit 2 one edge after the status inputs move, or after they first settle following reset. The bench checks the set-beats-clear cycle and the unmaskable wake path directly, because a fault there shows only in that one cycle or only with every enable at 0.

// File: rtl/can_irq_collector.sv
module can_irq_collector #(
  parameter int          SW       = 2,
  parameter logic [15:0] VEC_BASE = 16'h1FFA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_done,
  input  logic        tx_done,
  input  logic [SW-1:0] err_stat,
  input  logic [SW-1:0] bus_stat,
  input  logic [1:0]  buf_full,
  input  logic        msg_arrive,
  input  logic        bus_active,
  input  logic        sleep_mode,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq_req,
  output logic [15:0] vec_addr
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_SRC  = 2'd3;

  logic [4:0]      flags;
  logic [3:0]      enables;
  logic [2*SW-1:0] prev_st;
  logic            prev_vld;
  logic [4:0]      ev;
  logic [4:0]      clr;

  assign ev[0] = rx_done;
  assign ev[1] = tx_done;
  assign ev[2] = prev_vld && ({err_stat, bus_stat} != prev_st);
  assign ev[3] = msg_arrive && (&buf_full);
  assign ev[4] = bus_active && sleep_mode;

  assign clr = (reg_wr && reg_addr == A_SRC) ? reg_wdata[4:0] : 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags    <= '0;
      enables  <= '0;
      prev_st  <= '0;
      prev_vld <= 1'b0;
    end else begin
      flags    <= (flags & ~clr) | ev;
      prev_st  <= {err_stat, bus_stat};
      prev_vld <= 1'b1;
      if (reg_wr && reg_addr == A_CTRL) enables <= reg_wdata[3:0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {4'd0, enables};
      A_SRC:   reg_rdata = {3'd0, flags};
      default: reg_rdata = 8'd0;
    endcase
  end

  assign irq_req  = (|(flags[3:0] & enables)) | flags[4];
  assign vec_addr = VEC_BASE;

  a_r2_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> flags[0]);
  a_r3_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_vld && {err_stat, bus_stat} != prev_st) |=> flags[2]);
  a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_arrive && buf_full == 2'b11) |=> flags[3]);
  a_r5_wake_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[4] && !(bus_active && sleep_mode)) |=> !flags[4]);
  a_r6_wake_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    flags[4] |-> irq_req);
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_SRC && reg_wdata[1] && !tx_done) |=> !flags[1]);
endmodule

// File: tb/can_irq_collector_bench.sv
module can_irq_collector_bench;
  logic clk = 0, rst_n = 0;
  logic rx_done = 0, tx_done = 0, msg_arrive = 0, bus_active = 0, sleep_mode = 0;
  logic [1:0] err_stat = 2'b10, bus_stat = 0, buf_full = 0, reg_addr = 0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_req;
  logic [15:0] vec_addr;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  can_irq_collector u_can_irq_collector (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; step(); reg_wr = 0;
  endtask

  task automatic src(output logic [7:0] v);
    reg_addr = 3; #1 v = reg_rdata;
  endtask

  task automatic clear_all(); wr(3, 8'h1F); endtask

  task automatic t_reset();
    logic [7:0] v;
    reg_addr = 0; #1 chk("R1 ctrl", reg_rdata, 0);
    src(v); chk("R1 src", v, 0);
    chk("R1 irq", irq_req, 0);
  endtask

  task automatic t_rx_tx();
    logic [7:0] v;
    rx_done = 1; step(); rx_done = 0;
    src(v); chk("R2 rx", v, 8'h01);
    tx_done = 1; step(); tx_done = 0;
    src(v); chk("R2 tx", v, 8'h03);
    clear_all();
  endtask

  task automatic t_err();
    logic [7:0] v;
    step(); step();
    src(v); chk("R3 steady after reset", v, 0);
    bus_stat = 2'b01; step();
    src(v); chk("R3 rise", v, 8'h04);
    clear_all(); step(); step();
    src(v); chk("R3 steady", v, 0);
    err_stat = 2'b00; step();
    src(v); chk("R3 fall", v, 8'h04);
    clear_all();
  endtask

  task automatic t_ovr();
    logic [7:0] v;
    buf_full = 2'b01; msg_arrive = 1; step(); msg_arrive = 0;
    src(v); chk("R4 one buffer", v, 0);
    buf_full = 2'b11; msg_arrive = 1; step(); msg_arrive = 0; buf_full = 0;
    src(v); chk("R4 both buffers", v, 8'h08);
    clear_all();
  endtask

  task automatic t_wake();
    logic [7:0] v;
    bus_active = 1; step(); bus_active = 0;
    src(v); chk("R5 awake", v, 0);
    chk("R5 irq awake", irq_req, 0);
    sleep_mode = 1; bus_active = 1; step(); bus_active = 0; sleep_mode = 0;
    src(v); chk("R5 asleep", v, 8'h10);
    chk("R6 wake unmasked", irq_req, 1);
    clear_all();
    chk("R7 wake cleared irq", irq_req, 0);
  endtask

  task automatic t_mask();
    wr(0, 8'hFF);
    reg_addr = 0; #1 chk("R6 ctrl read", reg_rdata, 8'h0F);
    wr(0, 8'h02);
    rx_done = 1; step(); rx_done = 0;
    chk("R6 masked rx", irq_req, 0);
    tx_done = 1; step(); tx_done = 0;
    chk("R6 enabled tx", irq_req, 1);
    wr(3, 8'h02);
    chk("R6 after tx clear", irq_req, 0);
    wr(0, 8'h01);
    chk("R6 enable pending rx", irq_req, 1);
    clear_all(); wr(0, 0);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    rx_done = 1; tx_done = 1; step(); rx_done = 0; tx_done = 0;
    wr(3, 8'h01);
    src(v); chk("R7 partial clear", v, 8'h02);
    reg_addr = 3; reg_wdata = 8'h02; reg_wr = 1; tx_done = 1; step();
    reg_wr = 0; tx_done = 0;
    src(v); chk("R7 set wins", v, 8'h02);
    wr(3, 8'h02);
    src(v); chk("R7 cleared", v, 0);
  endtask

  task automatic t_map();
    logic [7:0] v;
    rx_done = 1; step(); rx_done = 0;
    wr(1, 8'hFF); wr(2, 8'hFF);
    reg_addr = 1; #1 chk("R9 off1", reg_rdata, 0);
    reg_addr = 2; #1 chk("R9 off2", reg_rdata, 0);
    reg_addr = 0; #1 chk("R9 ctrl kept", reg_rdata, 0);
    src(v); chk("R9 flag kept", v, 8'h01);
    clear_all();
  endtask

  task automatic t_vec();
    chk("R8 vector", vec_addr, 16'h1FFA);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step(); step();
    rst_n = 1;
    #1;
    t_reset();
    t_err();
    t_rx_tx();
    t_ovr();
    t_wake();
    t_mask();
    t_clear();
    t_map();
    t_vec();
    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule